// File: doc/BRIEF.md
# Edge-Selectable Capture Interrupt Unit

This block timestamps events on external pins. A free-running core counter advances once per clock while its run bit is set. Each of two capture channels watches one pin. When a channel is armed, a transition of the chosen polarity copies the live counter value into that channel's capture register. The same transition also raises the channel's request flag. Software reads the timestamps and flags through a small single-cycle register bus and clears flags by writing ones.

A channel is armed only when three conditions hold together: its mode field holds the capture code, its edge field selects at least one polarity, and its direction bit marks the pin as an input. Pins are asynchronous. Each pin passes through a two-stage synchronizer before edge detection, so a single pin change gives exactly one capture. That capture lands a fixed number of cycles after the change.

Top module: `edge_capture_unit`

## Requirements
- R1: A channel captures and flags only while its mode field (control bits [2:0]) equals 3'b101. With any other code, pin transitions change neither its capture register nor its flag.
- R2: The edge field is control bits [5:3], and bit 5 is ignored. Low bits 01 react to a rising pin edge, 10 to a falling edge, and 11 to both.
- R3: Edge low bits 00 disable capture and flagging, even in capture mode.
- R4: For a pin change applied just after the counter was read as T, the capture register holds T+2 (mod 2^16) while the counter runs. The new value is visible on the bus from the third rising clock edge after the change.
- R5: A qualifying event sets the channel's flag (flag word bit c for channel c). The flag stays set until a 1 is written to that bit of the flag word. Writing 0 leaves it unchanged.
- R6: If an event and a clear of the same flag fall in the same cycle, the flag stays set.
- R7: While a channel's direction bit (control bit 6) is 0, meaning output, its pin transitions are ignored.
- R8: The two channels are independent. An event on one pin never changes the other channel's capture register or flag.
- R9: The counter increments by one per clock while the run bit (bit 0 at address 1) is 1, and wraps from 16'hFFFF to 0. It holds while run is 0. A write to address 0 loads it.
- R10: After reset, every readable register is zero: counter, run bit, capture registers, control words and flags.
- R11: Register map, read combinationally on `bus_rdata`: 0 counter, 1 run, 2 capture 0, 3 capture 1, 4 control 0, 5 control 1, 6 flags. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 2 | Asynchronous event pins, one per channel |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, same cycle |

## Verification
A wrong synchronizer depth or a misplaced edge detector shows up as a capture value off by one or more counts from T+2. It appears on the first armed event, three clocks after the pin moves. A fault in the arming logic shows up either as a capture or flag where none is due, or as a missing one. Either is visible in the next read of the capture and flag words. Those reads happen a few cycles after each event, and the random mix of mode, edge, direction and polarity reaches each gating term. A flag that clears too eagerly or ignores its clear shows up in the first flag read after the clear write.

// File: rtl/cap_pkg.sv
// Package: shared constants and types for the edge capture unit.
// Assumes a control word of 7 bits: {dir, edge_sel[2:0], mode[2:0]}.
package cap_pkg;

    localparam logic [2:0] CAP_MODE = 3'b101;
    localparam int         CTRL_W   = 7;

    typedef struct packed {
        logic       dir;
        logic [2:0] edge_sel;
        logic [2:0] mode;
    } ch_ctrl_t;

    localparam int ADDR_TIMER = 0;
    localparam int ADDR_RUN   = 1;
    localparam int CAP_BASE   = 2;

endpackage

// File: rtl/cap_sync_edge.sv
// Module: cap_sync_edge
// Brings one asynchronous pin into the clock domain through STAGES flops,
// then flags rising/falling edges by comparing with a one-cycle-delayed copy.
// Assumes STAGES >= 2. Reset value of every flop is 0.
module cap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              synced;

    assign synced = chain_q[STAGES-1];

    // Shift the pin through the synchronizer and keep a delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= synced;
        end
    end

    // Edge pulses last one cycle per synchronized transition.
    always_comb begin
        rise = synced & ~prev_q;
        fall = ~synced & prev_q;
    end

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise || fall) || $past(chain_q[STAGES-2]) != $past(synced));

endmodule

// File: rtl/cap_timer.sv
// Module: cap_timer
// Free-running core counter: loads on request, else counts while run is set.
// Assumes load has priority over counting. Wraps naturally at 2^TW.
module cap_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] cnt
);

    // Count, load or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (run)   cnt <= cnt + TW'(1);
    end

    // R9
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> cnt == $past(cnt) + TW'(1));

    // R9
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));

    // R9
    timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt == '1) |=> cnt == '0);

endmodule

// File: rtl/cap_channel.sv
// Module: cap_channel
// One capture channel: qualifies edges by mode, edge select and direction,
// latches the core counter and sets a sticky request flag on each event.
// Assumes rise/fall are single-cycle synchronous pulses. Set beats clear.
module cap_channel import cap_pkg::*; #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  logic [2:0]    mode,
    input  logic [1:0]    edge_lo,
    input  logic          dir_in,
    input  logic [TW-1:0] timer_in,
    input  logic          clr,
    output logic [TW-1:0] cap_q,
    output logic          flag_q
);

    logic armed;
    logic evt;

    // An event needs capture mode, input direction and a selected polarity.
    always_comb begin
        armed = dir_in && (mode == CAP_MODE);
        evt   = armed && ((edge_lo[0] && rise) || (edge_lo[1] && fall));
    end

    // Latch the counter on each qualifying event.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap_q <= '0;
        else if (evt)  cap_q <= timer_in;
    end

    // Sticky flag: set on event, cleared by software unless set coincides.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= 1'b0;
        else           flag_q <= (flag_q && !clr) || evt;
    end

    // R4
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> cap_q == $past(timer_in));

    // R1
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != CAP_MODE) |=> $stable(cap_q));

    // R7
    dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_in |=> $stable(cap_q));

    // R3
    edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_lo == 2'b00 && !clr) |=> flag_q == $past(flag_q));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);

endmodule

// File: rtl/edge_capture_unit.sv
// Module: edge_capture_unit (top)
// Core counter, NCH capture channels with pin synchronizers, and a
// single-cycle register bus. Map: 0 counter, 1 run, CAP_BASE+c capture c,
// CAP_BASE+NCH+c control c, CAP_BASE+2*NCH flags (write 1 to clear).
// Assumes TW >= CTRL_W and TW >= NCH.
module edge_capture_unit import cap_pkg::*; #(
    parameter int TW  = 16,
    parameter int NCH = 2,
    parameter int AW  = $clog2(CAP_BASE + 2 * NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cap_pin,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [TW-1:0]  bus_wdata,
    output logic [TW-1:0]  bus_rdata
);

    localparam int CTL_BASE  = CAP_BASE + NCH;
    localparam int ADDR_FLAG = CAP_BASE + 2 * NCH;

    logic            wr_en;
    logic            run_q;
    logic            timer_load;
    logic [TW-1:0]   timer;
    ch_ctrl_t        ctrl_q [NCH];
    logic [TW-1:0]   cap    [NCH];
    logic [NCH-1:0]  flags;
    logic [NCH-1:0]  clr;
    logic [NCH-1:0]  rise;
    logic [NCH-1:0]  fall;

    // Decode write strobes for the counter load and flag clears.
    always_comb begin
        wr_en      = bus_sel && bus_wr;
        timer_load = wr_en && (bus_addr == AW'(ADDR_TIMER));
        for (int c = 0; c < NCH; c++) begin
            clr[c] = wr_en && (bus_addr == AW'(ADDR_FLAG)) && bus_wdata[c];
        end
    end

    // Run bit and per-channel control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            for (int c = 0; c < NCH; c++) ctrl_q[c] <= '0;
        end else if (wr_en) begin
            if (bus_addr == AW'(ADDR_RUN)) run_q <= bus_wdata[0];
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == AW'(CTL_BASE + c))
                    ctrl_q[c] <= ch_ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end
        end
    end

    cap_timer #(.TW(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .load     (timer_load),
        .load_val (bus_wdata),
        .cnt      (timer)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cap_sync_edge #(.STAGES(2)) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cap_pin[g]),
            .rise  (rise[g]),
            .fall  (fall[g])
        );

        cap_channel #(.TW(TW)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise     (rise[g]),
            .fall     (fall[g]),
            .mode     (ctrl_q[g].mode),
            .edge_lo  (ctrl_q[g].edge_sel[1:0]),
            .dir_in   (ctrl_q[g].dir),
            .timer_in (timer),
            .clr      (clr[g]),
            .cap_q    (cap[g]),
            .flag_q   (flags[g])
        );
    end

    // Combinational read mux over the register map.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_TIMER)) bus_rdata = timer;
        if (bus_addr == AW'(ADDR_RUN))   bus_rdata = TW'(run_q);
        if (bus_addr == AW'(ADDR_FLAG))  bus_rdata = TW'(flags);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(CAP_BASE + c)) bus_rdata = cap[c];
            if (bus_addr == AW'(CTL_BASE + c)) bus_rdata = TW'(ctrl_q[c]);
        end
    end

    // R10
    reset_flags_chk: assert property (@(posedge clk)
        !rst_n |=> flags == '0);

endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cap_pin = 2'b00;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] exp_cap [2];
    logic [1:0]  exp_flag;

    always #2 clk = ~clk;

    edge_capture_unit i_edge_capture_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pin   (cap_pin),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic bit fires(input logic [2:0] mode, input logic [2:0] esel,
                                 input logic dir, input logic oldv, input logic newv);
        bit r = !oldv && newv;
        bit f = oldv && !newv;
        return dir && (mode == 3'b101) && ((esel[0] && r) || (esel[1] && f));
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
        logic [15:0] v;
        rd(a, v);
        check(v === exp, req, v, exp);
    endtask

    // One pin toggle on channel ch; expected values from the model.
    task automatic toggle_and_check(input int ch, input logic [2:0] mode,
                                    input logic [2:0] esel, input logic dir, input string req);
        logic [15:0] t0;
        logic oldv;
        rd(3'd0, t0);
        oldv = cap_pin[ch];
        cap_pin[ch] = ~oldv;
        if (fires(mode, esel, dir, oldv, ~oldv)) begin
            exp_cap[ch]  = t0 + 16'd2;
            exp_flag[ch] = 1'b1;
        end
        repeat (4) @(negedge clk);
        rd_chk(3'(2 + ch), exp_cap[ch], {req, " capture"});
        rd_chk(3'(2 + (1 - ch)), exp_cap[1 - ch], "R8 other channel capture");
        rd_chk(3'd6, {14'd0, exp_flag}, {req, " flags"});
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        exp_cap[0] = '0; exp_cap[1] = '0; exp_flag = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state, R11 map
        for (int a = 0; a < 7; a++) rd_chk(3'(a), 16'd0, "R10 R11 reset value");

        // R9 hold, load, wrap
        wr(3'd0, 16'hFFFE);
        rd_chk(3'd0, 16'hFFFE, "R9 load");
        rd_chk(3'd0, 16'hFFFE, "R9 hold while stopped");
        wr(3'd1, 16'd1);
        rd_chk(3'd1, 16'd1, "R11 run readback");
        rd(3'd0, v);
        check(v == 16'hFFFF || v == 16'h0000, "R9 count", v, 16'hFFFF);
        rd(3'd0, v);
        rd_chk(3'd0, v + 16'd1, "R9 wrap step");

        // R11 control readback, edge top bit stored
        wr(3'd4, 16'h006D);
        rd_chk(3'd4, 16'h006D, "R11 control readback");

        // R2 rising only with top edge bit set: 6D -> dir1 edge101 mode101
        toggle_and_check(0, 3'b101, 3'b101, 1'b1, "R2 rise");
        toggle_and_check(0, 3'b101, 3'b101, 1'b1, "R2 fall ignored");
        // R5 write 0 keeps flag
        wr(3'd6, 16'd0);
        rd_chk(3'd6, {14'd0, exp_flag}, "R5 write zero");
        wr(3'd6, 16'd1); exp_flag[0] = 1'b0;
        rd_chk(3'd6, {14'd0, exp_flag}, "R5 clear");

        // R3 edge 00 in capture mode
        wr(3'd4, 16'h0045);
        toggle_and_check(0, 3'b101, 3'b000, 1'b1, "R3 edge off");

        // R7 output direction
        wr(3'd5, 16'h001D);
        toggle_and_check(1, 3'b101, 3'b011, 1'b0, "R7 output pin");

        // R6 event and clear in same cycle on channel 1
        wr(3'd5, 16'h005D);
        @(negedge clk);
        cap_pin[1] = ~cap_pin[1];
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 16'd2;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(3'd6, v);
        check(v[1] === 1'b1, "R6 set beats clear", {15'd0, v[1]}, 16'd1);
        wr(3'd6, 16'd3);
        rd(3'd3, v); exp_cap[1] = v;
        exp_flag = '0;

        // Random mix: R1 R2 R3 R4 R5 R7 R8
        for (int i = 0; i < 60; i++) begin
            int ch = int'($urandom % 2);
            logic [2:0] mode = ($urandom % 2) ? 3'b101 : 3'($urandom % 8);
            logic [2:0] esel = 3'($urandom % 8);
            logic dir = ($urandom % 4) != 0;
            wr(3'(4 + ch), {9'd0, dir, esel, mode});
            repeat (2) @(negedge clk);
            toggle_and_check(ch, mode, esel, dir, "R1 R2 R3 R4 R7");
            wr(3'd6, 16'd3);
            exp_flag = '0;
            rd_chk(3'd6, 16'd0, "R5 clear both");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule